// File: doc/BRIEF.md
# IO address translation unit

This block turns 32-bit device DMA addresses into 34-bit physical addresses. The mapping lives in a linear table in system memory, one 8-byte entry per 8 KB page. A 16-entry fully associative cache of recent translations sits in front of the table. Software programs three registers through a simple write port: a control word, the table's base address, and a flush register that drops the cached translation for one page.

The translation window always ends at the top of the 32-bit space. A 3-bit size code sets how far down the window reaches. A request that falls below the window, or that arrives while translation is disabled, is refused at once. A request that misses the cache costs exactly one table read over a single-beat memory read port. The entry that comes back is checked for its valid bit and, for writes, its writable bit. A good entry is kept in the cache and a bad one is not. The block serves one request at a time and returns either a physical address or a fault.

Top module: `iova_xlate`

## Requirements
- R1: After reset `rsp_valid` and `mem_rd_req` are low and `req_ready` is high. The cache is empty and translation is disabled, so the first request faults without a table read.
- R2: Register writes use `cfg_sel`. Code 0 is control: bit 0 enables translation and bits 18:16 hold size code n. Code 1 is the table base: bits 33:13 are kept and bits 12:0 read as zero. Code 2 is flush: bits 31:13 name the page. Code 3 writes nothing.
- R3: The window base is 0xFFFFE000 shifted left by n+10 and cut to 32 bits (n=0 gives 0xFF800000, n=7 gives 0xC0000000). A request below the base faults one cycle after acceptance with no table read. Address 0xFFFFFFFF is inside the window.
- R4: While the enable bit is 0, every request faults with no table read, even for a page held in the cache.
- R5: A request that misses issues one pulse of `mem_rd_req` one cycle after acceptance. The pulse carries address table_base + ((addr − base) >> 13) × 8. The response comes one cycle after `mem_rd_ack`.
- R6: In an entry, bit 63 is valid, bit 1 is writable, bit 4 is cacheable and bits 33:13 are the physical page. Entry bits above 33 are ignored. A good response gives `rsp_paddr` = {entry[33:13], addr[12:0]} and `rsp_cacheable` = entry[4].
- R7: An entry with bit 63 clear, or a write to an entry with bit 1 clear, gives a fault with `rsp_paddr` = 0 and `rsp_cacheable` = 0. Such an entry is not cached, so repeating the request reads the table again.
- R8: A request that hits the cache is answered one cycle after acceptance with no table read. A write that hits a cached read-only page faults.
- R9: A flush write drops the cached translation for its page only. Other cached pages still hit.
- R10: A flush for the page of a walk still in flight does not change that walk's response, but the result is not cached.
- R11: The cache holds 16 translations and replaces them round-robin. The 17th fill evicts the first, and the second one is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 table base, 2 flush) |
| cfg_wdata | input | 34 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | Request is a device write |
| req_addr | input | 32 | Device DMA address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Request refused |
| rsp_paddr | output | 34 | Physical address (zero on fault) |
| rsp_cacheable | output | 1 | Target is cacheable |
| mem_rd_req | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | 34 | Table entry address |
| mem_rd_ack | input | 1 | Table read data valid |
| mem_rd_data | input | 64 | Table entry |

## Verification
The hardest case to reach from the ports is a flush that arrives while a table walk is still waiting for memory. The bench's memory model answers after a fixed delay. It forks a flush write alongside the request so that the write falls inside that wait. The discarded fill then shows up as a second table read when the same page is requested again. Round-robin eviction is reached from reset by walking seventeen distinct valid pages and then probing the second page and the first page.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 34;
  localparam int PG_W   = 13;
  localparam int VPN_W  = VA_W - PG_W;
  localparam int PPN_W  = PA_W - PG_W;
  localparam int CODE_W = 3;
  localparam int SLOT_W = 10 + (1 << CODE_W) - 1;
  localparam int PTE_W  = 64;
  localparam int PTE_V  = 63;
  localparam int PTE_WR = 1;
  localparam int PTE_C  = 4;
  localparam logic [VA_W-1:0] WIN_TOP = 32'hFFFFE000;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TBASE = 2'd1,
    SEL_FLUSH = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             wr;
    logic             cach;
  } xl_data_t;

  // Lowest address of the window for a given size code.
  function automatic logic [VA_W-1:0] win_base(input logic [CODE_W-1:0] code);
    logic [2*VA_W-1:0] w;
    w = {{VA_W{1'b0}}, WIN_TOP} << (32'(code) + 32'd10);
    return w[VA_W-1:0];
  endfunction

  // Table slot of an in-window address.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [VA_W-1:0] a,
                                                input logic [CODE_W-1:0] code);
    return SLOT_W'((a - win_base(code)) >> PG_W);
  endfunction

  // Byte address of an entry.
  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] tbase,
                                               input logic [SLOT_W-1:0] s);
    return tbase + PA_W'({s, 3'b000});
  endfunction
endpackage

// File: rtl/iox_cfg.sv
module iox_cfg import iox_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PA_W-1:0]   cfg_wdata,
  output logic              xl_en,
  output logic [CODE_W-1:0] size_code,
  output logic [PA_W-1:0]   tbase,
  output logic              flush_vld,
  output logic [VPN_W-1:0]  flush_vpn
);
  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 16;

  logic [PPN_W-1:0] tbase_pg;
  cfg_sel_e         sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_en     <= 1'b0;
      size_code <= '0;
      tbase_pg  <= '0;
    end else if (cfg_we) begin
      if (sel == SEL_CTRL) begin
        xl_en     <= cfg_wdata[EN_BIT];
        size_code <= cfg_wdata[CODE_LSB +: CODE_W];
      end
      if (sel == SEL_TBASE) tbase_pg <= cfg_wdata[PA_W-1:PG_W];
    end
  end

  assign tbase     = {tbase_pg, {PG_W{1'b0}}};
  assign flush_vld = cfg_we && (sel == SEL_FLUSH);
  assign flush_vpn = cfg_wdata[VA_W-1:PG_W];

  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata[PG_W-1:EN_BIT+1];
endmodule

// File: rtl/iox_tlb.sv
module iox_tlb import iox_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output xl_data_t         lk_data,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  xl_data_t         fill_data,
  input  logic             flush_en,
  input  logic [VPN_W-1:0] flush_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int DAT_W = $bits(xl_data_t);

  logic [ENTRIES-1:0] vld, lk_match, fl_match;
  logic [VPN_W-1:0]   tag [ENTRIES];
  xl_data_t           dat [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic [DAT_W-1:0]   acc;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_way
    assign lk_match[i] = vld[i] && (tag[i] == lk_vpn);
    assign fl_match[i] = vld[i] && (tag[i] == flush_vpn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && rr == IDX_W'(i)) vld[i] <= 1'b1;
        else if (flush_en && fl_match[i]) vld[i] <= 1'b0;
      end
      if (fill_en) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && rr == IDX_W'(i)) begin
        tag[i] <= fill_vpn;
        dat[i] <= fill_data;
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) acc = acc | dat[i];
  end

  assign lk_hit  = |lk_match;
  assign lk_data = xl_data_t'(acc);

  // R11: no page is ever held twice
  p_one_way_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)) else $error("duplicate translation");

  // R9: a flushed page cannot hit on the following cycle
  p_flush_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> !(lk_hit && lk_vpn == $past(flush_vpn)))
    else $error("flushed page still hits");
endmodule

// File: rtl/iox_walk.sv
module iox_walk import iox_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en,
  input  logic [CODE_W-1:0] size_code,
  input  logic [PA_W-1:0]   tbase,
  input  logic              flush_vld,
  input  logic [VPN_W-1:0]  flush_vpn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_cacheable,
  output logic              mem_rd_req,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_hit,
  input  xl_data_t          lk_data,
  output logic              fill_en,
  output logic [VPN_W-1:0]  fill_vpn,
  output xl_data_t          fill_data
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              st;
  logic [VPN_W-1:0] pend_vpn;
  logic [PG_W-1:0]  pend_off;
  logic             pend_wr, cancel;
  logic             accept, in_win, hit_ok, hit_deny, flush_pend, pte_ok, walk_done;
  logic [VA_W-1:0]  base;

  assign base       = win_base(size_code);
  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign lk_vpn     = req_addr[VA_W-1:PG_W];
  assign in_win     = req_addr >= base;
  assign hit_ok     = lk_hit && !(flush_vld && flush_vpn == lk_vpn);
  assign hit_deny   = req_write && !lk_data.wr;
  assign flush_pend = flush_vld && (flush_vpn == pend_vpn);
  assign pte_ok     = mem_rd_data[PTE_V] && (!pend_wr || mem_rd_data[PTE_WR]);
  assign walk_done  = (st == ST_WAIT) && mem_rd_ack;
  assign fill_en    = walk_done && pte_ok && !cancel && !flush_pend;
  assign fill_vpn   = pend_vpn;
  assign fill_data  = '{ppn: mem_rd_data[PA_W-1:PG_W], wr: mem_rd_data[PTE_WR],
                        cach: mem_rd_data[PTE_C]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      pend_vpn      <= '0;
      pend_off      <= '0;
      pend_wr       <= 1'b0;
      cancel        <= 1'b0;
      mem_rd_req    <= 1'b0;
      mem_rd_addr   <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_req <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (!xl_en || !in_win) begin
            rsp_valid     <= 1'b1;
            rsp_fault     <= 1'b1;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
          end else if (hit_ok) begin
            rsp_valid     <= 1'b1;
            rsp_fault     <= hit_deny;
            rsp_paddr     <= hit_deny ? '0 : {lk_data.ppn, req_addr[PG_W-1:0]};
            rsp_cacheable <= !hit_deny && lk_data.cach;
          end else begin
            st          <= ST_WAIT;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= pte_addr(tbase, slot_of(req_addr, size_code));
            pend_vpn    <= lk_vpn;
            pend_off    <= req_addr[PG_W-1:0];
            pend_wr     <= req_write;
            cancel      <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (flush_pend) cancel <= 1'b1;
          if (mem_rd_ack) begin
            st            <= ST_IDLE;
            rsp_valid     <= 1'b1;
            rsp_fault     <= !pte_ok;
            rsp_paddr     <= pte_ok ? {mem_rd_data[PA_W-1:PG_W], pend_off} : '0;
            rsp_cacheable <= pte_ok && mem_rd_data[PTE_C];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Entry bits not used for translation
  logic unused_pte;
  assign unused_pte = ^{mem_rd_data[62:34], mem_rd_data[12:5], mem_rd_data[3:2],
                        mem_rd_data[0]};

  // R5: a table read only follows an accepted request
  p_walk_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> $past(accept)) else $error("stray table read");

  // R3: below-window requests fault next cycle with no read
  p_outside_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xl_en && !in_win |=> rsp_valid && rsp_fault && !mem_rd_req)
    else $error("out-of-window request not refused");

  // R4: disabled translation refuses everything without a read
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xl_en |=> rsp_valid && rsp_fault && !mem_rd_req)
    else $error("disabled request not refused");

  // R8: a hit answers next cycle without a read
  p_hit_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xl_en && in_win && hit_ok |=> rsp_valid && !mem_rd_req)
    else $error("hit went to memory");

  // R7: faulting responses carry no address and no cacheable flag
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_cacheable)
    else $error("fault with address");
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate import iox_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PA_W-1:0]   cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_cacheable,
  output logic              mem_rd_req,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [PTE_W-1:0]  mem_rd_data
);
  logic              xl_en, flush_vld, lk_hit, fill_en;
  logic [CODE_W-1:0] size_code;
  logic [PA_W-1:0]   tbase;
  logic [VPN_W-1:0]  flush_vpn, lk_vpn, fill_vpn;
  xl_data_t          lk_data, fill_data;

  iox_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xl_en(xl_en), .size_code(size_code),
    .tbase(tbase), .flush_vld(flush_vld), .flush_vpn(flush_vpn)
  );

  iox_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_data(lk_data), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_data(fill_data), .flush_en(flush_vld), .flush_vpn(flush_vpn)
  );

  iox_walk u_walk (
    .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .size_code(size_code),
    .tbase(tbase), .flush_vld(flush_vld), .flush_vpn(flush_vpn),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_data(fill_data)
  );
endmodule

// File: tb/iova_xlate_tb_top.sv
`timescale 1ns/1ps
module iova_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [33:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault, rsp_cacheable;
  logic [33:0] rsp_paddr;
  logic        mem_rd_req;
  logic [33:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [63:0] mem_rd_data = '0;

  int n_chk = 0, n_bad = 0, mem_reads = 0, mem_cnt = 0;
  logic [33:0] last_rd_addr = '0;
  logic [33:0] tb_cur = 34'h2_0010_0000;
  bit done = 0;

  always #4 clk = ~clk;

  iova_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  // Bench table contents: slot s is invalid when s%5==4, writable when even,
  // cacheable when s bit 1 is set; bits above 33 carry junk.
  function automatic logic [63:0] pte_of(input int s);
    logic [63:0] e;
    e = '0;
    e[63]    = (s % 5) != 4;
    e[1]     = (s % 2) == 0;
    e[4]     = ((s / 2) % 2) == 1;
    e[61]    = 1'b1;
    e[40:34] = 7'h55;
    e[33:13] = 21'((s * 37 + 'h1234) & 'h1FFFFF);
    return e;
  endfunction

  function automatic logic [31:0] base_of(input int code);
    return ~((32'h0080_0000 << code) - 32'd1);
  endfunction

  function automatic logic [33:0] exp_pa(input logic [31:0] a, input int code);
    logic [63:0] e;
    e = pte_of(int'((a - base_of(code)) / 32'd8192));
    return 34'((e & 64'h3_FFFF_E000) | 64'(a & 32'h1FFF));
  endfunction

  // Memory model: fixed latency of three falling edges after the request.
  initial forever begin
    @(negedge clk);
    mem_rd_ack = 1'b0;
    if (mem_rd_req) begin
      mem_reads++;
      last_rd_addr = mem_rd_addr;
      mem_cnt = 3;
    end else if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = pte_of(int'((last_rd_addr - tb_cur) >> 3));
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [33:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic xact(input logic wr, input logic [31:0] a, output logic f,
                      output logic [33:0] pa, output logic c, output int nr);
    int r0;
    int waited;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; r0 = mem_reads;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    f = rsp_fault; pa = rsp_paddr; c = rsp_cacheable; nr = mem_reads - r0;
    chk("response arrives", 64'(rsp_valid), 64'd1);
  endtask

  // Check one transaction against the bench's own expectation.
  task automatic run_one(input string tag, input logic wr, input logic [31:0] a,
                         input int code, input logic exp_f, input int exp_walk);
    logic f, c;
    logic [33:0] pa;
    int nr;
    logic [63:0] e;
    xact(wr, a, f, pa, c, nr);
    e = pte_of(int'((a - base_of(code)) / 32'd8192));
    chk({tag, " fault"}, 64'(f), 64'(exp_f));
    chk({tag, " table reads"}, 64'(nr), 64'(exp_walk));
    chk({tag, " paddr"}, 64'(pa), exp_f ? 64'd0 : 64'(exp_pa(a, code)));
    chk({tag, " cacheable"}, 64'(c), exp_f ? 64'd0 : 64'(e[4]));
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic        fault;
    logic        walk;
  } vec_t;
  localparam int NV = 12;
  // Size code 1: window base 0xFF000000.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hFF000010, 1'b0, 1'b1},  // R5 R6 slot 0 first touch
    '{1'b0, 32'hFF000100, 1'b0, 1'b0},  // R8 same page hits
    '{1'b1, 32'hFF002008, 1'b1, 1'b1},  // R7 write to read-only slot 1
    '{1'b1, 32'hFF002008, 1'b1, 1'b1},  // R7 not cached, walks again
    '{1'b0, 32'hFF002000, 1'b0, 1'b1},  // R6 read of slot 1 is fine
    '{1'b1, 32'hFF002004, 1'b1, 1'b0},  // R8 cached read-only page faults
    '{1'b0, 32'hFF008000, 1'b1, 1'b1},  // R7 invalid slot 4
    '{1'b0, 32'hFF008010, 1'b1, 1'b1},  // R7 invalid entry never cached
    '{1'b0, 32'hFEFFFFFC, 1'b1, 1'b0},  // R3 just below the window
    '{1'b0, 32'hFFFFFFFF, 1'b0, 1'b1},  // R3 very top of the window
    '{1'b1, 32'hFF004000, 1'b0, 1'b1},  // R6 writable slot 2
    '{1'b1, 32'hFF004ABC, 1'b0, 1'b0}   // R8 hit on writable page
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic f, c;
    logic [33:0] pa;
    int nr;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R1 mem_rd_req idle", 64'(mem_rd_req), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    run_one("R1 disabled after reset", 1'b0, 32'hFF000000, 1, 1'b1, 0);

    cfg_write(2'd1, tb_cur);
    cfg_write(2'd0, 34'h1_0001);     // R2 enable, size code 1
    for (int i = 0; i < NV; i++)
      run_one($sformatf("vector %0d", i), VECS[i].wr, VECS[i].addr, 1,
              VECS[i].fault, int'(VECS[i].walk));

    // R4: disabling refuses a cached page without reading
    cfg_write(2'd0, 34'h1_0000);
    run_one("R4 disabled cached page", 1'b0, 32'hFF000010, 1, 1'b1, 0);
    cfg_write(2'd0, 34'h1_0001);
    run_one("R4 re-enabled hit", 1'b0, 32'hFF000010, 1, 1'b0, 0);

    // R9: flush one page, neighbour stays
    cfg_write(2'd2, 34'h0_FF00_0ABC);
    run_one("R9 flushed page walks", 1'b0, 32'hFF000020, 1, 1'b0, 1);
    run_one("R9 other page still hits", 1'b0, 32'hFF004000, 1, 1'b0, 0);

    // R10: flush of the page being walked
    fork
      run_one("R10 walk with flush", 1'b0, 32'hFF006000, 1, 1'b0, 1);
      begin
        repeat (3) @(negedge clk);
        cfg_write(2'd2, 34'h0_FF00_6010);
      end
    join
    run_one("R10 fill was dropped", 1'b0, 32'hFF006008, 1, 1'b0, 1);
    run_one("R10 later fill kept", 1'b0, 32'hFF006008, 1, 1'b0, 0);

    // R3 R5: size code 0
    cfg_write(2'd0, 34'h0_0001);
    run_one("R3 below code-0 base", 1'b0, 32'hFF7FE000, 0, 1'b1, 0);
    run_one("R5 code 0 slot 1022", 1'b0, 32'hFFFFC000, 0, 1'b0, 1);
    chk("R5 entry address code 0", 64'(last_rd_addr), 64'(tb_cur + 34'd8176));

    // R2: table base drops its low bits; R3 R5: size code 7
    cfg_write(2'd1, 34'h3_FFC0_1FFF);
    tb_cur = 34'h3_FFC0_0000;
    cfg_write(2'd0, 34'h7_0001);
    run_one("R5 code 7 slot 1", 1'b0, 32'hC0002000, 7, 1'b0, 1);
    chk("R2 table base low bits cleared", 64'(last_rd_addr), 64'h3_FFC0_0008);
    run_one("R3 below code-7 base", 1'b0, 32'hBFFFFFF8, 7, 1'b1, 0);
    cfg_write(2'd3, 34'h0_0000);     // R2 select 3 writes nothing
    run_one("R2 select 3 no effect", 1'b0, 32'hC0002010, 7, 1'b0, 0);

    // R11: round-robin replacement from an empty cache
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    tb_cur = 34'h2_0010_0000;
    cfg_write(2'd1, tb_cur);
    cfg_write(2'd0, 34'h1_0001);
    for (int k = 0; k < 17; k++)
      run_one($sformatf("R11 fill %0d", k), 1'b0, 32'hFF000000 + 32'(k * 5 * 8192),
              1, 1'b0, 1);
    run_one("R11 second page kept", 1'b0, 32'hFF000000 + 32'(5 * 8192), 1, 1'b0, 0);
    run_one("R11 first page evicted", 1'b0, 32'hFF000000, 1, 1'b0, 1);

    xact(1'b0, 32'hFF000000, f, pa, c, nr);
    chk("R11 refilled page hits", 64'(nr), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule